// File: doc/BRIEF.md
# Remote Memory Write Access Sequencer

This block lets a remote master write into the memories of a local processor. When the remote side raises its write request, the sequencer takes bus ownership away from the local CPU. It then spends one T-state so that the local write strobe is known to be inactive, and a second T-state so that the remote address can settle. After that it drives the memory write strobe low. The strobe stays low for a programmed number of wait states. The count comes from one of two 3-bit settings, one for data memory and one for instruction memory, and the memory select decides which one is used. An external wait line can stretch the final wait state for as long as it is held low.

An acknowledge line, active low, holds off the remote master for the whole access. It rises together with the strobe when the write completes. One T-state later, ownership returns to the local CPU, and a pending local bus request is granted. The sequencer then stays in a termination state until the remote request is released. Only then can a new access begin.

All timing is counted in clock cycles of the T-state clock. Reset is synchronous and active high.

Top module: `remote_write_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the remote owner flag is 0, the write strobe is high (inactive), and the acknowledge is high (released).
- R2: One cycle after the remote request is sampled high in idle, the remote owner flag is 1 and the acknowledge is low. The acknowledge stays low, and ownership stays remote, for every cycle in which the write strobe is low.
- R3: After ownership turns remote, the write strobe stays high for exactly two cycles and then goes low.
- R4: With the wait line high, the write strobe is low for N+1 cycles. N is the data-memory count when the memory select was 0 at the request, and the instruction-memory count when it was 1. The select is sampled only at the request, and later changes to it are ignored.
- R5: If the wait line is low in the final wait-state cycle, the strobe stays low until the wait line is sampled high. A low wait line before the final wait state adds no cycles.
- R6: The write strobe and the acknowledge rise in the same cycle, while ownership is still remote.
- R7: Ownership returns to local one cycle after the acknowledge rises. The local grant equals the local request whenever ownership is local, and it is 0 whenever ownership is remote.
- R8: After completion, as long as the remote request stays high, ownership stays local, the acknowledge stays high and no new write begins. A new access needs the request to drop and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous reset, active high |
| rem_wr_req | input | 1 | Remote write request, active high |
| mem_sel | input | 1 | Target memory: 0 data, 1 instruction |
| wait_n | input | 1 | External wait, low stretches the last wait state |
| dmem_ws | input | WS_W | Data memory wait-state count |
| imem_ws | input | WS_W | Instruction memory wait-state count |
| lcl_breq | input | 1 | Local CPU bus request |
| remote_own | output | 1 | 1 while the remote master owns the memory buses |
| wr_strobe_n | output | 1 | Memory write strobe, active low |
| ack_n | output | 1 | Acknowledge to the remote side, low holds it off |
| lcl_bgnt | output | 1 | Bus grant to the local CPU |

## Verification
On every cycle, the assertions check the following: the two-cycle gap between taking the bus and lowering the strobe; the acknowledge and ownership while the strobe is low; the strobe and acknowledge rising together; the hand-back one cycle later; the grant masking; and the hold-on-wait at the final wait state. Only the bench scenarios can show that the strobe length matches the count of the selected memory space, that a late change of the select is ignored, that an early wait pulse adds nothing, and that a request held after completion starts no second write.

// File: rtl/remote_write_seq.sv
module remote_write_seq #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rem_wr_req,
  input  logic            mem_sel,
  input  logic            wait_n,
  input  logic [WS_W-1:0] dmem_ws,
  input  logic [WS_W-1:0] imem_ws,
  input  logic            lcl_breq,
  output logic            remote_own,
  output logic            wr_strobe_n,
  output logic            ack_n,
  output logic            lcl_bgnt
);
  typedef enum logic [2:0] {
    S_IDLE, S_TAKE, S_SETTLE, S_ACCESS, S_TERM, S_DONE
  } state_t;

  state_t          state, nxt;
  logic            sel_q;
  logic [WS_W-1:0] ws_cnt;
  logic            at_last;

  assign at_last = (state == S_ACCESS) && (ws_cnt == '0);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   if (rem_wr_req) nxt = S_TAKE;
      S_TAKE:   nxt = S_SETTLE;
      S_SETTLE: nxt = S_ACCESS;
      S_ACCESS: if (at_last && wait_n) nxt = S_TERM;
      S_TERM:   nxt = S_DONE;
      S_DONE:   if (!rem_wr_req) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      sel_q  <= 1'b0;
      ws_cnt <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && rem_wr_req) sel_q <= mem_sel;
      if (state == S_SETTLE) ws_cnt <= sel_q ? imem_ws : dmem_ws;
      else if (state == S_ACCESS && ws_cnt != '0) ws_cnt <= ws_cnt - 1'b1;
    end
  end

  assign remote_own  = (state == S_TAKE) || (state == S_SETTLE) ||
                       (state == S_ACCESS) || (state == S_TERM);
  assign wr_strobe_n = (state != S_ACCESS);
  assign ack_n       = !((state == S_TAKE) || (state == S_SETTLE) || (state == S_ACCESS));
  assign lcl_bgnt    = lcl_breq && !remote_own;
endmodule

module remote_write_seq_chk (
  input logic clk,
  input logic rst,
  input logic remote_own,
  input logic wr_strobe_n,
  input logic ack_n,
  input logic lcl_bgnt,
  input logic lcl_breq,
  input logic wait_n,
  input logic at_last
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!remote_own && wr_strobe_n && ack_n));
  assert_strobe_held_off_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_strobe_n |-> (!ack_n && remote_own));
  assert_two_cycle_gap_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(remote_own) |-> wr_strobe_n ##1 wr_strobe_n ##1 !wr_strobe_n);
  assert_wait_extends_R5: assert property (@(posedge clk) disable iff (rst)
    (at_last && !wait_n) |=> !wr_strobe_n);
  assert_ack_with_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_strobe_n) |-> (ack_n && remote_own));
  assert_handback_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_n) && remote_own) |=> !remote_own);
  assert_grant_mask_R7: assert property (@(posedge clk) disable iff (rst)
    lcl_bgnt == (lcl_breq && !remote_own));
endmodule

bind remote_write_seq remote_write_seq_chk u_chk (
  .clk(clk), .rst(rst), .remote_own(remote_own), .wr_strobe_n(wr_strobe_n),
  .ack_n(ack_n), .lcl_bgnt(lcl_bgnt), .lcl_breq(lcl_breq), .wait_n(wait_n),
  .at_last(at_last)
);

// File: tb/remote_write_seq_bench.sv
module remote_write_seq_bench;
  logic clk = 0, rst = 1, rem_wr_req = 0, mem_sel = 0, wait_n = 1, lcl_breq = 0;
  logic [2:0] dmem_ws = 0, imem_ws = 0;
  logic remote_own, wr_strobe_n, ack_n, lcl_bgnt;
  int tests = 0, fails = 0, cycles = 0;
  int exp_q[$];
  int low_cnt = 0;
  logic prev_low = 0;

  remote_write_seq u_remote_write_seq (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (remote_own) check("R7 no grant while remote", lcl_bgnt, 0);
      if (!wr_strobe_n) low_cnt++;
      else if (prev_low) begin
        if (exp_q.size() == 0) check("R4 unexpected write", 1, 0);
        else check("R4/R5 strobe length", low_cnt, exp_q.pop_front());
        check("R6 ack rises with strobe", ack_n, 1);
        check("R6 still remote at completion", remote_own, 1);
        low_cnt = 0;
      end
      prev_low = !wr_strobe_n;
    end
  end

  task automatic do_write(input logic sel, input int hold, input int keep);
    int ws = sel ? int'(imem_ws) : int'(dmem_ws);
    int k = 0;
    exp_q.push_back(hold > ws + 1 ? hold : ws + 1);
    mem_sel = sel;
    wait_n = (hold > 0) ? 1'b0 : 1'b1;
    rem_wr_req = 1;
    @(negedge clk);
    check("R2 remote owns after request", remote_own, 1);
    check("R2 ack low after request", ack_n, 0);
    check("R3 strobe high first cycle", wr_strobe_n, 1);
    mem_sel = ~sel;
    @(negedge clk);
    check("R3 strobe high second cycle", wr_strobe_n, 1);
    @(negedge clk);
    check("R3 strobe low third cycle", wr_strobe_n, 0);
    while (!wr_strobe_n && k < 64) begin
      k++;
      if (k == hold) wait_n = 1;
      @(negedge clk);
    end
    wait_n = 1;
    @(negedge clk);
    check("R7 ownership back to local", remote_own, 0);
    check("R7 grant follows local request", lcl_bgnt, lcl_breq);
    for (int i = 0; i < keep; i++) begin
      @(negedge clk);
      check("R8 held request stays local", remote_own, 0);
      check("R8 held request ack high", ack_n, 1);
      check("R8 held request no new write", wr_strobe_n, 1);
    end
    rem_wr_req = 0;
    @(negedge clk);
    check("R8 idle after release", remote_own, 0);
  endtask

  initial begin
    rem_wr_req = 1;
    repeat (3) @(negedge clk);
    check("R1 reset owner", remote_own, 0);
    check("R1 reset strobe", wr_strobe_n, 1);
    check("R1 reset ack", ack_n, 1);
    rem_wr_req = 0;
    rst = 0;
    @(negedge clk);
    check("R1 after reset owner", remote_own, 0);
    check("R1 after reset ack", ack_n, 1);
    lcl_breq = 1;
    @(negedge clk);
    check("R7 grant when local", lcl_bgnt, 1);
    dmem_ws = 3; imem_ws = 5;
    do_write(0, 0, 0);
    do_write(1, 9, 3);
    dmem_ws = 0;
    do_write(0, 0, 1);
    do_write(0, 3, 0);
    imem_ws = 7;
    do_write(1, 2, 2);
    lcl_breq = 0;
    do_write(1, 0, 0);
    repeat (4) @(negedge clk);
    check("R4 all writes observed", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule